// File: doc/BRIEF.md
# Watchdog and Alarm Interrupt Controller

This block produces the two interrupt requests of a timekeeping subsystem. The first source is a watchdog (interval) timer. Software loads it with a four-digit BCD value in units of 0.01 s, so the interval runs from 0.01 s to 99.99 s. It then counts down once for every centisecond tick. When it expires it raises a flag and reloads itself. The second source is a time-of-day alarm. It compares the seconds, minutes, hours and day of week that the calendar supplies against programmed values. Each field has its own "don't care" bit, so the alarm can fire once a week, once a day, once an hour or once a minute.

A small byte-wide register port gives access to the watchdog value, the alarm fields, a control byte and a flag byte. A read or write of either watchdog byte restarts the countdown, and that is how software kicks the watchdog. The control byte chooses which source drives output A; output B always carries the other source. It also selects pulse or level behaviour for A and the active sense of B. The outputs model open-drain pins: a 1 on `inta_pull` or `intb_pull` means the pin is pulled low.

Register map (3-bit address): 0 watchdog hundredths (BCD), 1 watchdog seconds (BCD), 2 alarm seconds, 3 alarm minutes, 4 alarm hours, 5 alarm day, 6 control, 7 flags. Each alarm byte holds its value in bits 6:0 and its mask in bit 7. Control bits: 0 alarm enable, 1 watchdog enable, 2 swap (1 puts the watchdog on A and the alarm on B), 3 A pulse mode, 4 B active-high. Flag bits: 0 alarm, 1 watchdog.

Top module: `wdog_alarm_irq`

## Requirements
- R1: Registers 0 to 6 read back the last value written to them. Reads of address 7 return the flags, with bit 0 for the alarm and bit 1 for the watchdog.
- R2: After the watchdog is loaded with BCD value N (seconds:hundredths), the watchdog flag sets on the edge that samples the N-th centisecond tick, and not before. The countdown borrows across BCD digits, so 01.00 takes 100 ticks.
- R3: Any read or write of address 0 or 1 reloads the countdown from the programmed value, which restarts the full interval.
- R4: A programmed watchdog value of 00.00 never sets the watchdog flag.
- R5: The alarm flag sets on the edge where every unmasked field becomes equal to the current time. A field whose bit 7 is set always counts as equal. The alarm does not fire again while the match persists.
- R6: Flags latch whatever the enable bits are. A read of address 7 returns the flags and clears them on that edge.
- R7: A source whose enable bit (control bit 0 or 1) is clear never asserts its interrupt output.
- R8: With control bit 2 clear, the alarm drives A and the watchdog drives B. With bit 2 set, the two are swapped.
- R9: In level mode (control bit 3 clear), A stays asserted while its source flag and enable are set, until the flag is read. In pulse mode, A asserts for exactly PULSE_CYC cycles per enabled event.
- R10: When control bit 4 is clear, B pulls while asserted. When bit 4 is set, B pulls while idle and releases while asserted.
- R11: After reset, every register and flag is zero and neither output pulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_tick | input | 1 | One-cycle pulse every 0.01 s |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_day | input | 3 | Current day of week |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears flags at address 7) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| inta_pull | output | 1 | Output A open-drain pull enable |
| intb_pull | output | 1 | Output B open-drain pull enable |

## Verification
Every result is registered once. A flag set by a tick, by a time match or by a flag-clearing read can be seen on the outputs and the flags after the same clock edge that samples the stimulus. The bench drives inputs on the falling edge and reads outputs on the next falling edge. For the watchdog it counts out N-1 ticks, checks that nothing has fired, then gives the N-th tick and checks again. A pulse on A is due from the event edge for PULSE_CYC cycles. The bench samples its last asserted cycle and the first released cycle.

// File: rtl/wai_pkg.sv
// Shared constants for the watchdog/alarm interrupt controller.
// Assumes a byte-wide register port with a 3-bit address.
package wai_pkg;
    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADR_WD_CS  = 3'd0;
    localparam logic [REG_AW-1:0] ADR_WD_S   = 3'd1;
    localparam logic [REG_AW-1:0] ADR_AL_S   = 3'd2;
    localparam logic [REG_AW-1:0] ADR_AL_M   = 3'd3;
    localparam logic [REG_AW-1:0] ADR_AL_H   = 3'd4;
    localparam logic [REG_AW-1:0] ADR_AL_D   = 3'd5;
    localparam logic [REG_AW-1:0] ADR_CTRL   = 3'd6;
    localparam logic [REG_AW-1:0] ADR_FLAG   = 3'd7;

    // Number of plain storage bytes (addresses 0..5)
    localparam int N_STORE = 6;

    typedef struct packed {
        logic [2:0] spare;
        logic       b_high;     // output B active-high
        logic       a_pulse;    // output A pulse mode
        logic       swap;       // watchdog on A, alarm on B
        logic       wd_en;
        logic       al_en;
    } ctrl_t;

    // Flag bit positions
    localparam int FLG_AL = 0;
    localparam int FLG_WD = 1;
endpackage

// File: rtl/wai_regs.sv
// Register file: watchdog value, alarm fields, control and sticky flags.
// Assumes one access per cycle; a read of the flag byte clears it, and an
// event arriving on that same edge is kept.
module wai_regs
    import wai_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [REG_DW-1:0]   bus_wdata,
    input  logic                al_evt,
    input  logic                wd_evt,
    output logic [REG_DW-1:0]   bus_rdata,
    output logic                wd_reload,
    output logic [2*REG_DW-1:0] wd_val,
    output logic [2*REG_DW-1:0] wd_val_nx,
    output logic [4*REG_DW-1:0] al_flds,
    output ctrl_t               ctrl,
    output logic [1:0]          flags
);
    logic [REG_DW-1:0] store_q [N_STORE];
    logic [N_STORE-1:0] wr_hit;
    logic              flag_rd;

    // Decode one write strobe per storage byte
    for (genvar g = 0; g < N_STORE; g++) begin : g_hit
        assign wr_hit[g] = bus_wr && (bus_addr == REG_AW'(g));
    end

    // Storage bytes: reset to zero, load on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_STORE; i++) store_q[i] <= '0;
        end else begin
            for (int i = 0; i < N_STORE; i++)
                if (wr_hit[i]) store_q[i] <= bus_wdata;
        end
    end

    // Control byte
    always_ff @(posedge clk) begin
        if (!rst_n)                                ctrl <= '0;
        else if (bus_wr && bus_addr == ADR_CTRL)   ctrl <= ctrl_t'(bus_wdata);
    end

    assign flag_rd = bus_rd && (bus_addr == ADR_FLAG);

    // Sticky flags: set by events, cleared by a flag read, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flag_rd ? 2'b00 : flags) | {wd_evt, al_evt};
    end

    assign wd_reload = (bus_wr || bus_rd) &&
                       (bus_addr == ADR_WD_CS || bus_addr == ADR_WD_S);
    assign wd_val    = {store_q[1], store_q[0]};
    assign wd_val_nx = {wr_hit[1] ? bus_wdata : store_q[1],
                        wr_hit[0] ? bus_wdata : store_q[0]};
    assign al_flds   = {store_q[5], store_q[4], store_q[3], store_q[2]};

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_CTRL)       bus_rdata = ctrl;
        else if (bus_addr == ADR_FLAG)  bus_rdata = {{(REG_DW-2){1'b0}}, flags};
        else                            bus_rdata = store_q[bus_addr];
    end
endmodule

// File: rtl/wai_wdog.sv
// BCD countdown for the watchdog. Loads on reload, steps once per tick,
// fires on the tick that takes it from 1 and then reloads itself.
// Assumes the load value is valid BCD; a zero value leaves it idle.
module wai_wdog #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic         evt,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0]      cnt_q;
    logic [W-1:0]      cnt_dec;
    logic [DIGITS:0]   borrow;

    // Borrow chain through the BCD digits
    assign borrow[0] = 1'b1;
    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] d;
        assign d = cnt_q[4*g +: 4];
        assign borrow[g+1] = borrow[g] && (d == 4'd0);
        assign cnt_dec[4*g +: 4] = !borrow[g] ? d :
                                   (d == 4'd0) ? 4'd9 : d - 4'd1;
    end

    assign evt = tick && !reload && (cnt_q == W'(1));

    // Countdown register
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (reload || evt)          cnt_q <= load_val;
        else if (tick && cnt_q != '0)    cnt_q <= cnt_dec;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wai_alarm.sv
// Time-of-day comparator. Each field carries a mask in its top bit; the
// event fires on the cycle the full match goes from false to true.
// Assumes field values and current time share the same BCD coding.
module wai_alarm #(
    parameter int NF = 4,
    parameter int BW = 8,
    localparam int FW = BW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NF*FW-1:0] cur,
    input  logic [NF*BW-1:0] flds,
    output logic           evt
);
    logic [NF-1:0] fld_ok;
    logic          match;
    logic          match_q;

    for (genvar g = 0; g < NF; g++) begin : g_fld
        assign fld_ok[g] = flds[g*BW + FW] ||
                           (flds[g*BW +: FW] == cur[g*FW +: FW]);
    end

    assign match = &fld_ok;
    assign evt   = match && !match_q;

    // Previous match, reset high so reset itself never fires the alarm
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match;
    end
endmodule

// File: rtl/wai_irq.sv
// Routes the two sources onto outputs A and B, shapes A as pulse or level,
// and applies the sense of B. Outputs are open-drain pull enables.
// Assumes PULSE_CYC >= 1.
module wai_irq #(
    parameter int PULSE_CYC = 8,
    localparam int CW = $clog2(PULSE_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] flags,
    input  logic       al_evt,
    input  logic       wd_evt,
    input  logic       al_en,
    input  logic       wd_en,
    input  logic       swap,
    input  logic       a_pulse,
    input  logic       b_high,
    output logic       inta_pull,
    output logic       intb_pull
);
    logic          a_flag, a_en, a_evt;
    logic          b_flag, b_en, b_act;
    logic [CW-1:0] pcnt_q;

    // Source selection
    always_comb begin
        a_flag = swap ? flags[1] : flags[0];
        a_en   = swap ? wd_en    : al_en;
        a_evt  = swap ? wd_evt   : al_evt;
        b_flag = swap ? flags[0] : flags[1];
        b_en   = swap ? al_en    : wd_en;
    end

    // Pulse-width counter for output A
    always_ff @(posedge clk) begin
        if (!rst_n)                        pcnt_q <= '0;
        else if (!a_pulse)                 pcnt_q <= '0;
        else if (a_evt && a_en)            pcnt_q <= CW'(PULSE_CYC);
        else if (pcnt_q != '0)             pcnt_q <= pcnt_q - 1'b1;
    end

    assign inta_pull = a_pulse ? (pcnt_q != '0) : (a_flag && a_en);
    assign b_act     = b_flag && b_en;
    assign intb_pull = b_high ? !b_act : b_act;
endmodule

// File: rtl/wdog_alarm_irq.sv
// Top of the watchdog/alarm interrupt controller: register file, BCD
// watchdog countdown, alarm comparator and output routing.
// Assumes cs_tick is a single-cycle pulse and time inputs are stable BCD.
module wdog_alarm_irq
    import wai_pkg::*;
#(
    parameter int PULSE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_tick,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [6:0]        cur_hour,
    input  logic [2:0]        cur_day,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    output logic              inta_pull,
    output logic              intb_pull
);
    localparam int WD_W   = 2 * REG_DW;
    localparam int WD_DIG = WD_W / 4;
    localparam int FW     = REG_DW - 1;

    logic              al_evt, wd_evt, wd_reload;
    logic [WD_W-1:0]   wd_val, wd_val_nx, wd_cnt;
    logic [4*REG_DW-1:0] al_flds;
    logic [4*FW-1:0]   cur_vec;
    ctrl_t             ctrl;
    logic [1:0]        flags;

    assign cur_vec = {{(FW-3){1'b0}}, cur_day, cur_hour, cur_min, cur_sec};

    wai_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .al_evt(al_evt), .wd_evt(wd_evt),
        .bus_rdata(bus_rdata), .wd_reload(wd_reload),
        .wd_val(wd_val), .wd_val_nx(wd_val_nx), .al_flds(al_flds),
        .ctrl(ctrl), .flags(flags)
    );

    wai_wdog #(.DIGITS(WD_DIG)) u_wdog (
        .clk(clk), .rst_n(rst_n), .tick(cs_tick), .reload(wd_reload),
        .load_val(wd_val_nx), .evt(wd_evt), .cnt_o(wd_cnt)
    );

    wai_alarm #(.NF(4), .BW(REG_DW)) u_alarm (
        .clk(clk), .rst_n(rst_n), .cur(cur_vec), .flds(al_flds), .evt(al_evt)
    );

    wai_irq #(.PULSE_CYC(PULSE_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .flags(flags),
        .al_evt(al_evt), .wd_evt(wd_evt),
        .al_en(ctrl.al_en), .wd_en(ctrl.wd_en), .swap(ctrl.swap),
        .a_pulse(ctrl.a_pulse), .b_high(ctrl.b_high),
        .inta_pull(inta_pull), .intb_pull(intb_pull)
    );
endmodule

// File: rtl/wai_chk.sv
// Temporal checks for the watchdog/alarm interrupt controller, bound to
// the top module.
module wai_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_rd,
    input logic [2:0]   bus_addr,
    input logic         al_evt,
    input logic         wd_evt,
    input logic         wd_reload,
    input logic [1:0]   flags,
    input logic [W-1:0] wd_val,
    input logic [W-1:0] wd_cnt
);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd7 && !al_evt && !wd_evt) |=> (flags == 2'b00));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !(bus_rd && bus_addr == 3'd7)) |=> flags[0]);

    // R2
    wd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_evt |=> (wd_cnt == $past(wd_val)));

    // R4
    wd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_val == '0 && !wd_reload) |-> !wd_evt);

    // R5
    al_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        al_evt |=> !al_evt);
endmodule

bind wdog_alarm_irq wai_chk #(.W(2 * wai_pkg::REG_DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .al_evt(al_evt), .wd_evt(wd_evt), .wd_reload(wd_reload),
    .flags(flags), .wd_val(wd_val), .wd_cnt(wd_cnt)
);

// File: tb/wdog_alarm_irq_tb.sv
`timescale 1ns/1ps
module wdog_alarm_irq_tb;
    localparam int PULSE_CYC = 8;
    localparam int NVEC = 7;

    // {al_sec, al_min, al_hr, al_day, cur_sec, cur_min, cur_hr, cur_day, fire}
    localparam logic [64:0] VEC [NVEC] = '{
        {8'h00, 8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h03, 1'b1},
        {8'h00, 8'h30, 8'h12, 8'h03, 8'h00, 8'h31, 8'h12, 8'h03, 1'b0},
        {8'h00, 8'h30, 8'h12, 8'h03, 8'h00, 8'h30, 8'h12, 8'h04, 1'b0},
        {8'h00, 8'h30, 8'h12, 8'h80, 8'h00, 8'h30, 8'h12, 8'h05, 1'b1},
        {8'h15, 8'h80, 8'h80, 8'h80, 8'h15, 8'h47, 8'h09, 8'h02, 1'b1},
        {8'h15, 8'h80, 8'h80, 8'h80, 8'h16, 8'h47, 8'h09, 8'h02, 1'b0},
        {8'h00, 8'h45, 8'h80, 8'h80, 8'h00, 8'h45, 8'h22, 8'h06, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_tick = 1'b0;
    logic [6:0] cur_sec = 7'h59, cur_min = 7'h59, cur_hour = 7'h23;
    logic [2:0] cur_day = 3'd7;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       inta_pull, intb_pull;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    wdog_alarm_irq #(.PULSE_CYC(PULSE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_tick(cs_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .inta_pull(inta_pull), .intb_pull(intb_pull)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(negedge clk); cs_tick = 1'b1; end
        @(negedge clk); cs_tick = 1'b0;
    endtask

    task automatic park_time();
        @(negedge clk);
        cur_sec = 7'h59; cur_min = 7'h59; cur_hour = 7'h23; cur_day = 3'd7;
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 inta", {7'd0, inta_pull}, 8'd0);
        check("R11 intb", {7'd0, intb_pull}, 8'd0);
        rd(3'd6, rv); check("R11 ctrl", rv, 8'h00);
        rd(3'd7, rv); check("R11 flags", rv, 8'h00);

        // R1 readback
        wr(3'd3, 8'hA5); rd(3'd3, rv); check("R1 alarm byte", rv, 8'hA5);
        wr(3'd6, 8'h01); rd(3'd6, rv); check("R1 ctrl", rv, 8'h01);

        // R5 alarm table, alarm on A in level mode (R9)
        for (int i = 0; i < NVEC; i++) begin
            logic [64:0] v;
            v = VEC[i];
            park_time();
            wr(3'd2, v[64:57]); wr(3'd3, v[56:49]);
            wr(3'd4, v[48:41]); wr(3'd5, v[40:33]);
            rd(3'd7, rv);
            @(negedge clk);
            cur_sec = v[31:25]; cur_min = v[23:17];
            cur_hour = v[15:9]; cur_day = v[3:1];
            @(negedge clk);
            check($sformatf("R5 vec%0d inta", i), {7'd0, inta_pull}, {7'd0, v[0]});
            rd(3'd7, rv);
            check($sformatf("R5 vec%0d flag", i), rv, {7'd0, v[0]});
            check($sformatf("R9 vec%0d inta after read", i), {7'd0, inta_pull}, 8'd0);
        end
        park_time();

        // R2 watchdog on B, active low
        wr(3'd6, 8'h02);
        wr(3'd1, 8'h00); wr(3'd0, 8'h05);
        tick(4);
        check("R2 not yet", {7'd0, intb_pull}, 8'd0);
        tick(1);
        check("R8 wd on B", {7'd0, intb_pull}, 8'd1);
        rd(3'd7, rv); check("R6 wd flag", rv, 8'h02);
        check("R9 B cleared", {7'd0, intb_pull}, 8'd0);

        // R3 kick by reading the watchdog byte
        wr(3'd0, 8'h05);
        tick(3); rd(3'd0, rv); tick(3);
        rd(3'd7, rv); check("R3 kicked", rv, 8'h00);
        tick(2);
        rd(3'd7, rv); check("R3 expiry after kick", rv, 8'h02);

        // R2 BCD borrow: 01.00 = 100 ticks
        wr(3'd1, 8'h01); wr(3'd0, 8'h00);
        tick(99);
        rd(3'd7, rv); check("R2 borrow 99", rv, 8'h00);
        tick(1);
        rd(3'd7, rv); check("R2 borrow 100", rv, 8'h02);

        // R4 zero disables
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        tick(250);
        rd(3'd7, rv); check("R4 zero", rv, 8'h00);
        check("R4 B idle", {7'd0, intb_pull}, 8'd0);

        // R7 enables off, flag still latched
        wr(3'd6, 8'h00); wr(3'd0, 8'h03);
        tick(3);
        check("R7 A gated", {7'd0, inta_pull}, 8'd0);
        check("R7 B gated", {7'd0, intb_pull}, 8'd0);
        rd(3'd7, rv); check("R6 flag without enable", rv, 8'h02);

        // R10 B active high
        wr(3'd6, 8'h12);
        @(negedge clk);
        check("R10 idle pulls", {7'd0, intb_pull}, 8'd1);
        wr(3'd0, 8'h02); tick(2);
        check("R10 asserted releases", {7'd0, intb_pull}, 8'd0);
        rd(3'd7, rv);
        check("R10 back to idle", {7'd0, intb_pull}, 8'd1);

        // R8 swap + R9 pulse on A
        wr(3'd6, 8'h0E); wr(3'd0, 8'h02);
        tick(2);
        check("R9 pulse start", {7'd0, inta_pull}, 8'd1);
        repeat (PULSE_CYC - 1) @(negedge clk);
        check("R9 pulse last", {7'd0, inta_pull}, 8'd1);
        @(negedge clk);
        check("R9 pulse end", {7'd0, inta_pull}, 8'd0);
        rd(3'd7, rv); check("R6 flag after pulse", rv, 8'h02);

        // R8 swapped alarm goes to B
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
        wr(3'd6, 8'h05);
        park_time();
        wr(3'd2, 8'h10); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
        rd(3'd7, rv);
        @(negedge clk); cur_sec = 7'h10;
        @(negedge clk);
        check("R8 alarm on B", {7'd0, intb_pull}, 8'd1);
        check("R8 A quiet", {7'd0, inta_pull}, 8'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule